// File: doc/BRIEF.md
# Serial Bus Slave Address and Acknowledge Controller

This block is the protocol layer of a slave on a single-wire, self-clocked serial bus. It sits behind the receiver, which turns the line into decoded bytes, master acknowledge bits, error flags and a strobe for the long idle-high reset pulse (the standby pulse). The controller checks the start header. It matches this device's address in either the one-byte or the two-byte format. It tells the transmit side when a slave acknowledge bit must be driven. It hands the command byte and the data bytes that follow to the application.

The address format is chosen at build time. In the one-byte format the family code sits in the upper nibble and the device code in the lower nibble. In the two-byte format the first byte carries the reserved nibble `1111` above a family code, and the second byte is the full device code. The family code is a parameter and the device code is an input.

When a byte does not match, or when any framing or sequencing error occurs, the block goes silent. It then requests no acknowledge and ignores every byte until the next standby pulse. After an operation ends cleanly with a stop acknowledge, the same device may be addressed again with a new header and no standby pulse.

Top module: `sbs_slave_ctrl`

## Requirements
- R1: After reset the block is silent: `selected_o`, `sak_req_o`, `cmd_vld_o` and `data_vld_o` stay low and all traffic is ignored until `standby_i` is seen.
- R2: A `standby_i` strobe, in any state and over any other input in that cycle, clears `selected_o` and arms the block to expect a start header.
- R3: The first byte after arming must be 0x55, and the master acknowledge that follows must be 1. No acknowledge is requested for the header, and a different header byte makes the block silent.
- R4: With `ADDR12`=0 the address byte must equal `{FAMILY, dev_code_i[3:0]}`. A match raises `selected_o` in the cycle after the byte.
- R5: With `ADDR12`=1 the first address byte must equal `{4'b1111, FAMILY}` and gets no acknowledge. The second must equal `dev_code_i[7:0]`, and a match raises `selected_o`.
- R6: A mismatching address byte requests no acknowledge, leaves `selected_o` low and makes the block ignore all traffic until `standby_i`.
- R7: The first byte after a complete address gives a one-cycle `cmd_vld_o` pulse, one cycle after the byte strobe, with `cmd_o` equal to that byte. Later bytes of the operation pulse `data_vld_o` and show the byte on `data_o`. Both values hold between pulses.
- R8: Once the full address has matched, every master acknowledge for the address byte, the command byte or a data byte gives a one-cycle `sak_req_o` pulse in the cycle after the acknowledge strobe.
- R9: A master acknowledge of 0 after an acknowledged byte ends the operation, still with an acknowledge, and keeps `selected_o`. A following header and a matching address are accepted without a standby pulse.
- R10: `err_i`, a byte strobe when an acknowledge bit is due, an acknowledge strobe when a byte is due, or both strobes in one cycle make the block silent and clear `selected_o`.
- R11: A master acknowledge of 0 after the header or after the first byte of a two-byte address makes the block silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standby_i | input | 1 | Standby pulse detected (one-cycle strobe) |
| byte_vld_i | input | 1 | A decoded byte is present on `byte_i` |
| byte_i | input | 8 | Decoded byte, most significant bit received first |
| mak_vld_i | input | 1 | A master acknowledge bit is present on `mak_i` |
| mak_i | input | 1 | Master acknowledge value: 1 continue, 0 stop |
| err_i | input | 1 | Receiver detected a line or timing error |
| dev_code_i | input | 4 or 8 | This device's code (8 bits when `ADDR12`=1) |
| selected_o | output | 1 | This device holds the bus for the current or last operation |
| sak_req_o | output | 1 | Drive a slave acknowledge 1 in the coming slot |
| cmd_vld_o | output | 1 | Command byte strobe |
| cmd_o | output | 8 | Last command byte |
| data_vld_o | output | 1 | Data byte strobe |
| data_o | output | 8 | Last data byte |

## Verification
On every cycle the assertions check several properties. An acknowledge request only follows an acknowledge strobe, and only while the device is selected. The silent state persists until a standby pulse. A standby pulse or a fault always deselects the device. The command strobe carries the byte that came just before it. Whether the right byte in the right position is accepted or refused can only be shown by the bench's scenarios. That covers the header value, each address format, mismatches in either address byte, errors in the byte and acknowledge ordering, and the restart after a clean stop. In those scenarios a behavioural model predicts every output on every clock for both address formats.

// File: rtl/sbs_pkg.sv
// Shared definitions for the serial bus slave controller.
// Assumes byte-oriented decoded input from a separate receiver.
package sbs_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam logic [BYTE_W-1:0] HDR_PATTERN = 8'h55;
    localparam logic [NIB_W-1:0]  WIDE_MARK   = 4'hF;

    // Protocol position: byte slots and the acknowledge slots that follow them.
    typedef enum logic [3:0] {
        ST_OFF,      // silent until standby
        ST_HDR,      // header byte due
        ST_HDR_MAK,  // acknowledge after header due
        ST_AHI,      // first (or only) address byte due
        ST_AHI_MAK,  // acknowledge after first of two address bytes
        ST_ALO,      // second address byte due
        ST_ADR_MAK,  // acknowledge after the complete address
        ST_CMD,      // command byte due
        ST_CMD_MAK,  // acknowledge after command
        ST_DAT,      // data byte due
        ST_DAT_MAK   // acknowledge after data
    } state_t;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_BYTE,
        EV_MAK,
        EV_FAULT
    } ev_t;

    // True for states where an acknowledge bit, not a byte, is due.
    function automatic logic mak_due(input state_t s);
        return (s == ST_HDR_MAK) || (s == ST_AHI_MAK) || (s == ST_ADR_MAK) ||
               (s == ST_CMD_MAK) || (s == ST_DAT_MAK);
    endfunction

endpackage

// File: rtl/sbs_event_classify.sv
// Turns the receiver strobes into one event per cycle.
// Assumes the current protocol position says whether a byte or an ack is due;
// anything out of order, doubled or flagged by the receiver becomes a fault.
module sbs_event_classify
    import sbs_pkg::*;
(
    input  logic   byte_vld_i,
    input  logic   mak_vld_i,
    input  logic   err_i,
    input  state_t st_i,
    output ev_t    ev_o
);

    logic want_mak;

    // Decide which event the strobes represent in the current position.
    always_comb begin
        want_mak = mak_due(st_i);
        if (err_i || (byte_vld_i && mak_vld_i)) begin
            ev_o = EV_FAULT;
        end else if (byte_vld_i) begin
            ev_o = want_mak ? EV_FAULT : EV_BYTE;
        end else if (mak_vld_i) begin
            ev_o = want_mak ? EV_MAK : EV_FAULT;
        end else begin
            ev_o = EV_IDLE;
        end
    end

endmodule

// File: rtl/sbs_addr_match.sv
// Compares a received byte with this device's address bytes.
// The generate picks one-byte or two-byte addressing; in one-byte mode the
// second comparison is never used and ties low.
module sbs_addr_match
    import sbs_pkg::*;
#(
    parameter bit               ADDR12 = 1'b0,
    parameter logic [NIB_W-1:0] FAMILY = 4'hA,
    localparam int              DEV_W  = ADDR12 ? BYTE_W : NIB_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [DEV_W-1:0]  dev_code_i,
    output logic              first_ok_o,
    output logic              second_ok_o
);

    generate
        if (ADDR12) begin : g_wide
            // Two-byte address: reserved mark plus family, then device code.
            always_comb begin
                first_ok_o  = (byte_i == {WIDE_MARK, FAMILY});
                second_ok_o = (byte_i == dev_code_i);
            end
        end else begin : g_narrow
            // One-byte address: family over device code.
            always_comb begin
                first_ok_o  = (byte_i == {FAMILY, dev_code_i});
                second_ok_o = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/sbs_ctrl_fsm.sv
// Protocol state machine: walks header, address, command and data slots,
// decides selection, requests slave acknowledges and shuts off on any
// mismatch or fault until a standby pulse. Assumes one event per cycle.
module sbs_ctrl_fsm
    import sbs_pkg::*;
#(
    parameter bit ADDR12 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  ev_t               ev_i,
    input  logic              mak_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              first_ok_i,
    input  logic              second_ok_i,
    output state_t            st_o,
    output logic              selected_o,
    output logic              sak_req_o,
    output logic              cmd_take_o,
    output logic              data_take_o
);

    state_t st_q, st_n;
    logic   sel_q, sel_n;
    logic   sak_q, sak_n;

    // Next-state, selection and acknowledge decisions for this cycle's event.
    always_comb begin
        st_n        = st_q;
        sel_n       = sel_q;
        sak_n       = 1'b0;
        cmd_take_o  = 1'b0;
        data_take_o = 1'b0;
        if (standby_i) begin
            st_n  = ST_HDR;
            sel_n = 1'b0;
        end else if (st_q != ST_OFF) begin
            unique case (ev_i)
                EV_FAULT: begin
                    st_n  = ST_OFF;
                    sel_n = 1'b0;
                end
                EV_BYTE: begin
                    unique case (st_q)
                        ST_HDR: begin
                            if (byte_i == HDR_PATTERN) begin
                                st_n = ST_HDR_MAK;
                            end else begin
                                st_n  = ST_OFF;
                                sel_n = 1'b0;
                            end
                        end
                        ST_AHI: begin
                            if (first_ok_i) begin
                                st_n  = ADDR12 ? ST_AHI_MAK : ST_ADR_MAK;
                                sel_n = ADDR12 ? sel_q : 1'b1;
                            end else begin
                                st_n  = ST_OFF;
                                sel_n = 1'b0;
                            end
                        end
                        ST_ALO: begin
                            if (second_ok_i) begin
                                st_n  = ST_ADR_MAK;
                                sel_n = 1'b1;
                            end else begin
                                st_n  = ST_OFF;
                                sel_n = 1'b0;
                            end
                        end
                        ST_CMD: begin
                            cmd_take_o = 1'b1;
                            st_n       = ST_CMD_MAK;
                        end
                        ST_DAT: begin
                            data_take_o = 1'b1;
                            st_n        = ST_DAT_MAK;
                        end
                        default: begin
                            st_n  = ST_OFF;
                            sel_n = 1'b0;
                        end
                    endcase
                end
                EV_MAK: begin
                    unique case (st_q)
                        ST_HDR_MAK: begin
                            st_n  = mak_i ? ST_AHI : ST_OFF;
                            sel_n = mak_i ? sel_q : 1'b0;
                        end
                        ST_AHI_MAK: begin
                            st_n  = mak_i ? ST_ALO : ST_OFF;
                            sel_n = mak_i ? sel_q : 1'b0;
                        end
                        ST_ADR_MAK: begin
                            sak_n = 1'b1;
                            st_n  = mak_i ? ST_CMD : ST_HDR;
                        end
                        ST_CMD_MAK, ST_DAT_MAK: begin
                            sak_n = 1'b1;
                            st_n  = mak_i ? ST_DAT : ST_HDR;
                        end
                        default: begin
                            st_n  = ST_OFF;
                            sel_n = 1'b0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // State and output registers; reset leaves the block silent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            sel_q <= 1'b0;
            sak_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            sel_q <= sel_n;
            sak_q <= sak_n;
        end
    end

    assign st_o       = st_q;
    assign selected_o = sel_q;
    assign sak_req_o  = sak_q;

    // An acknowledge request only ever follows an acknowledge event.
    p_sak_after_mak_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sak_q |-> $past(ev_i == EV_MAK));

    // Acknowledges are only requested for a selected device.
    p_sak_needs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sak_q |-> sel_q);

    // Standby always deselects and suppresses acknowledges.
    p_standby_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!sel_q && !sak_q && st_q == ST_HDR));

    // A silent block stays silent until standby.
    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !standby_i) |=> (st_q == ST_OFF && !sak_q && !sel_q));

    // Faults in a live block shut it off.
    p_fault_kills_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_FAULT && !standby_i) |=> (st_q == ST_OFF && !sel_q));

    // No acknowledge for the header slot.
    p_no_hdr_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HDR_MAK && ev_i == EV_MAK) |=> !sak_q);

endmodule

// File: rtl/sbs_byte_handoff.sv
// Registers command and data bytes toward the application with one-cycle
// valid strobes. Values hold between strobes. Assumes take strobes are
// mutually exclusive.
module sbs_byte_handoff
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_take_i,
    input  logic              data_take_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              cmd_vld_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              data_vld_o,
    output logic [BYTE_W-1:0] data_o
);

    // Capture command and data bytes and pulse their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld_o  <= 1'b0;
            data_vld_o <= 1'b0;
            cmd_o      <= '0;
            data_o     <= '0;
        end else begin
            cmd_vld_o  <= cmd_take_i;
            data_vld_o <= data_take_i;
            if (cmd_take_i) begin
                cmd_o <= byte_i;
            end
            if (data_take_i) begin
                data_o <= byte_i;
            end
        end
    end

    // Command and data strobes never coincide.
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld_o && data_vld_o));

endmodule

// File: rtl/sbs_slave_ctrl.sv
// Slave address-match and acknowledge controller. Sits behind a byte
// receiver and in front of the transmit side and the application.
// Assumes receiver strobes are single-cycle and standby is a strobe.
module sbs_slave_ctrl
    import sbs_pkg::*;
#(
    parameter bit               ADDR12 = 1'b0,
    parameter logic [NIB_W-1:0] FAMILY = 4'hA,
    localparam int              DEV_W  = ADDR12 ? BYTE_W : NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              mak_vld_i,
    input  logic              mak_i,
    input  logic              err_i,
    input  logic [DEV_W-1:0]  dev_code_i,
    output logic              selected_o,
    output logic              sak_req_o,
    output logic              cmd_vld_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              data_vld_o,
    output logic [BYTE_W-1:0] data_o
);

    state_t st;
    ev_t    ev;
    logic   first_ok, second_ok;
    logic   cmd_take, data_take;

    sbs_event_classify u_classify (
        .byte_vld_i (byte_vld_i),
        .mak_vld_i  (mak_vld_i),
        .err_i      (err_i),
        .st_i       (st),
        .ev_o       (ev)
    );

    sbs_addr_match #(
        .ADDR12 (ADDR12),
        .FAMILY (FAMILY)
    ) u_match (
        .byte_i      (byte_i),
        .dev_code_i  (dev_code_i),
        .first_ok_o  (first_ok),
        .second_ok_o (second_ok)
    );

    sbs_ctrl_fsm #(
        .ADDR12 (ADDR12)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby_i),
        .ev_i        (ev),
        .mak_i       (mak_i),
        .byte_i      (byte_i),
        .first_ok_i  (first_ok),
        .second_ok_i (second_ok),
        .st_o        (st),
        .selected_o  (selected_o),
        .sak_req_o   (sak_req_o),
        .cmd_take_o  (cmd_take),
        .data_take_o (data_take)
    );

    sbs_byte_handoff u_handoff (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_take_i  (cmd_take),
        .data_take_i (data_take),
        .byte_i      (byte_i),
        .cmd_vld_o   (cmd_vld_o),
        .cmd_o       (cmd_o),
        .data_vld_o  (data_vld_o),
        .data_o      (data_o)
    );

    // The command strobe carries the byte seen on the previous cycle.
    p_cmd_from_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> ($past(byte_vld_i) && cmd_o == $past(byte_i)));

    // Data strobes likewise follow a byte strobe.
    p_data_from_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld_o |-> ($past(byte_vld_i) && data_o == $past(byte_i)));

endmodule

// File: tb/sbs_slave_ctrl_bench.sv
// Behavioural reference: tracks the byte index within an operation.
module sbs_ref_model #(
    parameter bit ADDR12 = 1'b0,
    parameter int FAM    = 10,
    parameter int DEV    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       bv,
    input  logic [7:0] b,
    input  logic       mv,
    input  logic       m,
    input  logic       err,
    output logic [19:0] exp_o
);
    bit   live, awaiting, ack_due, sel, sak, cv, dv;
    int   nbytes;
    logic [7:0] cmd_b, dat_b;

    function automatic int addr_byte(input int k);
        if (ADDR12) return (k == 1) ? (240 + FAM) : DEV;
        return FAM * 16 + DEV;
    endfunction

    always @(posedge clk) begin
        int naddr;
        bit ok;
        naddr = ADDR12 ? 2 : 1;
        sak = 0; cv = 0; dv = 0;
        if (!rst_n) begin
            live = 0; awaiting = 0; ack_due = 0; sel = 0; nbytes = 0;
            cmd_b = 0; dat_b = 0;
        end else if (standby) begin
            live = 1; awaiting = 0; sel = 0; nbytes = 0;
        end else if (live) begin
            if (err || (bv && mv) || (bv && awaiting) || (mv && !awaiting)) begin
                live = 0; sel = 0;
            end else if (bv) begin
                ok = 1;
                if (nbytes == 0) begin
                    ok = (b == 8'h55); ack_due = 0;
                end else if (nbytes <= naddr) begin
                    ok = (int'(b) == addr_byte(nbytes));
                    ack_due = (nbytes == naddr);
                    if (ok && ack_due) sel = 1;
                end else if (nbytes == naddr + 1) begin
                    cv = 1; cmd_b = b; ack_due = 1;
                end else begin
                    dv = 1; dat_b = b; ack_due = 1;
                end
                if (ok) awaiting = 1;
                else begin live = 0; sel = 0; end
            end else if (mv) begin
                awaiting = 0;
                if (ack_due) begin
                    sak = 1;
                    nbytes = m ? nbytes + 1 : 0;
                end else if (m) begin
                    nbytes = nbytes + 1;
                end else begin
                    live = 0; sel = 0;
                end
            end
        end
        exp_o <= {sel, sak, cv, cmd_b, dv, dat_b};
    end
endmodule

module sbs_slave_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 0, bv = 0, mv = 0, m = 0, err = 0;
    logic [7:0] b = 8'h00;
    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    logic       sel_n, sak_n, cv_n, dv_n, sel_w, sak_w, cv_w, dv_w;
    logic [7:0] cmd_n, dat_n, cmd_w, dat_w;
    logic [19:0] exp_n, exp_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_slave_ctrl #(.ADDR12(1'b0), .FAMILY(4'hA)) u_sbs_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .standby_i(standby), .byte_vld_i(bv),
        .byte_i(b), .mak_vld_i(mv), .mak_i(m), .err_i(err),
        .dev_code_i(4'h3), .selected_o(sel_n), .sak_req_o(sak_n),
        .cmd_vld_o(cv_n), .cmd_o(cmd_n), .data_vld_o(dv_n), .data_o(dat_n));

    sbs_slave_ctrl #(.ADDR12(1'b1), .FAMILY(4'h5)) u_sbs_slave_ctrl_wide (
        .clk(clk), .rst_n(rst_n), .standby_i(standby), .byte_vld_i(bv),
        .byte_i(b), .mak_vld_i(mv), .mak_i(m), .err_i(err),
        .dev_code_i(8'hC7), .selected_o(sel_w), .sak_req_o(sak_w),
        .cmd_vld_o(cv_w), .cmd_o(cmd_w), .data_vld_o(dv_w), .data_o(dat_w));

    sbs_ref_model #(.ADDR12(1'b0), .FAM(10), .DEV(3)) u_ref_n (
        .clk(clk), .rst_n(rst_n), .standby(standby), .bv(bv), .b(b),
        .mv(mv), .m(m), .err(err), .exp_o(exp_n));

    sbs_ref_model #(.ADDR12(1'b1), .FAM(5), .DEV(199)) u_ref_w (
        .clk(clk), .rst_n(rst_n), .standby(standby), .bv(bv), .b(b),
        .mv(mv), .m(m), .err(err), .exp_o(exp_w));

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Compare both instances with the model on every falling edge.
    always @(negedge clk) begin
        logic [19:0] act_n, act_w;
        act_n = {sel_n, sak_n, cv_n, cmd_n, dv_n, dat_n};
        act_w = {sel_w, sak_w, cv_w, cmd_w, dv_w, dat_w};
        if (!done) begin
            checks++;
            if (act_n !== exp_n) begin
                fails++;
                $display("FAIL %s one-byte mode: actual %h expected %h", cur_req, act_n, exp_n);
            end
            checks++;
            if (act_w !== exp_w) begin
                fails++;
                $display("FAIL %s two-byte mode: actual %h expected %h", cur_req, act_w, exp_w);
            end
        end
    end

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic put_byte(input logic [7:0] v);
        @(negedge clk); bv = 1; b = v;
        @(negedge clk); bv = 0;
    endtask

    task automatic put_mak(input logic v);
        @(negedge clk); mv = 1; m = v;
        @(negedge clk); mv = 0;
    endtask

    task automatic pulse_standby();
        @(negedge clk); standby = 1;
        @(negedge clk); standby = 0;
    endtask

    task automatic pulse_err();
        @(negedge clk); err = 1;
        @(negedge clk); err = 0;
    endtask

    task automatic hdr();
        put_byte(8'h55); put_mak(1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: traffic before any standby is ignored
        cur_req = "R1";
        hdr(); put_byte(8'hA3); put_mak(1'b1); put_byte(8'h11); put_mak(1'b1);
        // R2: standby arms the block
        cur_req = "R2";
        pulse_standby();
        // R4 / R8: one-byte address match and acknowledges
        cur_req = "R4";
        hdr(); put_byte(8'hA3); put_mak(1'b1);
        // R7: command then data bytes
        cur_req = "R7";
        put_byte(8'h12); put_mak(1'b1);
        put_byte(8'h34); put_mak(1'b1);
        cur_req = "R9";
        put_byte(8'h56); put_mak(1'b0);
        // R9: restart without standby, same device
        hdr(); put_byte(8'hA3); put_mak(1'b1);
        cur_req = "R8";
        put_byte(8'h9E); put_mak(1'b0);
        // R2: standby while selected clears it
        cur_req = "R2";
        hdr(); put_byte(8'hA3); put_mak(1'b1);
        pulse_standby();
        // R6: mismatch then ignored traffic
        cur_req = "R6";
        hdr(); put_byte(8'hA4); put_mak(1'b1); put_byte(8'h20); put_mak(1'b1);
        hdr(); put_byte(8'hA3); put_mak(1'b1);
        pulse_standby();
        // R3: wrong header byte
        cur_req = "R3";
        put_byte(8'h54); put_mak(1'b1); hdr(); put_byte(8'hA3); put_mak(1'b1);
        pulse_standby();
        // R11: stop acknowledge after header
        cur_req = "R11";
        put_byte(8'h55); put_mak(1'b0); put_byte(8'hA3); put_mak(1'b1);
        pulse_standby();
        // R10: receiver error mid command
        cur_req = "R10";
        hdr(); put_byte(8'hA3); put_mak(1'b1); pulse_err();
        put_byte(8'h12); put_mak(1'b1);
        pulse_standby();
        // R10: byte when acknowledge due
        hdr(); put_byte(8'hA3); put_byte(8'h12); put_mak(1'b1);
        pulse_standby();
        // R10: acknowledge when byte due
        hdr(); put_mak(1'b1); put_byte(8'hA3); put_mak(1'b1);
        pulse_standby();
        // R10: both strobes together
        hdr();
        @(negedge clk); bv = 1; b = 8'hA3; mv = 1; m = 1;
        @(negedge clk); bv = 0; mv = 0;
        put_mak(1'b1);
        // R2: standby wins over a simultaneous byte
        cur_req = "R2";
        @(negedge clk); standby = 1; bv = 1; b = 8'h55;
        @(negedge clk); standby = 0; bv = 0;
        hdr(); put_byte(8'hA3); put_mak(1'b0);
        pulse_standby();
        // R5: two-byte address
        cur_req = "R5";
        hdr(); put_byte(8'hF5); put_mak(1'b1); put_byte(8'hC7); put_mak(1'b1);
        put_byte(8'h09); put_mak(1'b1); put_byte(8'h77); put_mak(1'b0);
        hdr(); put_byte(8'hF5); put_mak(1'b1); put_byte(8'hC7); put_mak(1'b0);
        // R6: second address byte mismatch
        cur_req = "R6";
        hdr(); put_byte(8'hF5); put_mak(1'b1); put_byte(8'hC6); put_mak(1'b1);
        put_byte(8'h01); put_mak(1'b1);
        pulse_standby();
        hdr(); put_byte(8'hF4); put_mak(1'b1); put_byte(8'hC7); put_mak(1'b1);
        pulse_standby();
        // R11: stop acknowledge after first of two address bytes
        cur_req = "R11";
        hdr(); put_byte(8'hF5); put_mak(1'b0); put_byte(8'hC7); put_mak(1'b1);
        repeat (3) @(negedge clk);
        done = 1;
        report();
    end
endmodule